// File: doc/BRIEF.md
# Windowed Observable Shift String

A long string of flip-flops that all move one place on every clock, with an optional even number of inverters between neighbouring flops. It serves as a radiation or fault target whose entire contents can be observed from outside without stopping the shift. The tail of the string is brought out through a four-bit window that is reloaded on every fourth clock. A divide-by-four strobe runs alongside the window, so an external capture device can sample it synchronously and see every bit that leaves the string exactly once.

Reset is active low. It reaches every flop asynchronously, but its release passes through a two-flop filter, so all flops leave reset on the same clock edge. The string length and the inverter count per stage are parameters. The default string has 300 flops and no inverters. Much longer strings are allowed; 10,000 flops is a typical upper case.

Top module: `shift_window_string`

## Requirements
- R1: Every flop in the string moves on every clock, with no enable. A bit sampled from `ser_in` on a clock edge reaches the last flop CHAIN_LEN edges later, with the same value.
- R2: On every fourth clock, `win_q` is reloaded with the last four flops of the string. Bit 0 holds the oldest bit, which is the one in the last flop; bit 3 holds the flop four places from the end. Between reloads `win_q` holds its value. Consecutive windows cover consecutive string bits, with no gap and no overlap.
- R3: `win_clk` runs at one quarter of the clock rate. It is high for two clocks and low for two clocks. It falls on the edge that reloads `win_q` and rises two clocks later, in the middle of the window's stable time.
- R4: INV_PER_STAGE sets the number of inverters between consecutive flops. Only 0, 8 and 20 are accepted; any other value stops elaboration. Because the count is even, data reaches the tail with its original polarity.
- R5: CHAIN_LEN is a parameter with a default of 300 and a minimum of 4. A string of exactly 4 flops behaves the same way as a long one.
- R6: While `rst_n` is low, every string flop, `win_q` and `win_clk` are 0. A low level on `rst_n` clears them at once, without waiting for a clock edge.
- R7: The release of `rst_n` passes through two filter flops, and the divide-by-four phase restarts from 0. Counting posedges after `rst_n` rises: the string first samples `ser_in` on the third edge, `win_clk` first goes high after the fourth edge, and that first strobe shows the all-zero reset window.
- R8: A single 1 placed in a stream of zeros appears in exactly one window, in exactly one bit, and is then flushed by the zeros behind it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low reset; clears asynchronously, released through a two-flop filter |
| ser_in | input | 1 | Serial data into the head of the string |
| win_q | output | 4 | Observation window; bit 0 is the oldest bit, from the last flop |
| win_clk | output | 1 | Divide-by-four strobe; window is stable around its rising edge |

## Verification
The bench builds two instances from the same stimulus. The first uses 300 flops with 8 inverters per stage: this checks the default length, that a deep inverter chain keeps polarity, and that windows stay seamless over a long stream. The second uses 4 flops with 20 inverters per stage. This is the shortest legal string: the window then spans the whole string, and any off-by-one in the load timing or in the prefill alignment shows up at once. Both instances go through an asynchronous reset in the middle of a run, so the filtered release and the restart of the strobe phase are seen twice.

// File: rtl/shift_window_string.sv
module shift_window_string #(
  parameter int unsigned CHAIN_LEN     = 300,
  parameter int unsigned INV_PER_STAGE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  output logic [3:0] win_q,
  output logic       win_clk
);
  localparam int unsigned WIN_W   = 4;
  localparam int unsigned PHASE_W = $clog2(WIN_W);
  localparam logic [PHASE_W-1:0] PH_LOAD = PHASE_W'(WIN_W - 1);
  localparam logic [PHASE_W-1:0] PH_HI_A = PHASE_W'(WIN_W/2 - 1);
  localparam logic [PHASE_W-1:0] PH_HI_B = PHASE_W'(WIN_W/2);

  if (CHAIN_LEN < WIN_W) begin : g_len_bad
    $fatal(1, "CHAIN_LEN must be at least the window width");
  end
  if (INV_PER_STAGE != 0 && INV_PER_STAGE != 8 && INV_PER_STAGE != 20) begin : g_inv_bad
    $fatal(1, "INV_PER_STAGE must be 0, 8 or 20");
  end

  logic [1:0] rst_meta;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_meta <= 2'b00;
    else        rst_meta <= {rst_meta[0], 1'b1};
  end
  assign rst_sync_n = rst_meta[1];

  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] chain_d;

  for (genvar s = 0; s < CHAIN_LEN; s++) begin : g_stage
    logic prev;
    logic inv_out;
    if (s == 0) begin : g_head
      assign prev = ser_in;
    end else begin : g_link
      assign prev = chain_q[s-1];
    end
    always_comb begin
      inv_out = prev;
      for (int k = 0; k < int'(INV_PER_STAGE); k++) inv_out = ~inv_out;
    end
    assign chain_d[s] = inv_out;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chain_q <= '0;
    else             chain_q <= chain_d;
  end

  logic [WIN_W-1:0] tail;
  for (genvar i = 0; i < WIN_W; i++) begin : g_tail
    assign tail[i] = chain_q[CHAIN_LEN-1-i];
  end

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= '0;
      win_clk <= 1'b0;
      win_q   <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
      win_clk <= (phase_q == PH_HI_A) || (phase_q == PH_HI_B);
      if (phase_q == PH_LOAD) win_q <= tail;
    end
  end
endmodule

module shift_window_string_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [3:0] win_q,
  input logic       win_clk,
  input logic [3:0] tail,
  input logic       head0,
  input logic       head1
);
  AST_HEAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    head1 == $past(head0)); // R1

  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(win_clk) |-> win_q == $past(tail)); // R2

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$fell(win_clk) |-> $stable(win_q)); // R2

  AST_STROBE_HIGH2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(win_clk) |=> win_clk); // R3

  AST_STROBE_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_clk && $past(win_clk)) |=> !win_clk); // R3

  AST_STROBE_LOW2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(win_clk) |=> !win_clk); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (win_q == 4'h0 && !win_clk && !head0)); // R6
endmodule

bind shift_window_string shift_window_string_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .win_q      (win_q),
  .win_clk    (win_clk),
  .tail       (tail),
  .head0      (chain_q[0]),
  .head1      (chain_q[1])
);

// File: tb/test_shift_window_string.sv
`timescale 1ns/100ps
module test_shift_window_string;
  localparam int LEN_A = 300;
  localparam int LEN_B = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic [3:0] win_a, win_b;
  logic wclk_a, wclk_b;

  always #2.5 clk = ~clk;

  shift_window_string #(.CHAIN_LEN(LEN_A), .INV_PER_STAGE(8)) i_shift_window_string (
    .clk(clk), .rst_n(rst_n), .ser_in(din), .win_q(win_a), .win_clk(wclk_a));

  shift_window_string #(.CHAIN_LEN(LEN_B), .INV_PER_STAGE(20)) i_shift_window_string_short (
    .clk(clk), .rst_n(rst_n), .ser_in(din), .win_q(win_b), .win_clk(wclk_b));

  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;
  int rel_edge = 0;
  int last_a = 0;
  int last_b = 0;
  int ones_a = 0;
  bit sb_on = 0;
  bit first_a = 0;
  bit first_b = 0;
  bit count_on = 0;
  bit done = 0;
  bit q_a[$];
  bit q_b[$];
  logic prev_a = 1'b0;
  logic prev_b = 1'b0;
  logic [3:0] exp_a, exp_b;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prefill();
    q_a.delete();
    q_b.delete();
    repeat (LEN_A + 1) q_a.push_back(1'b0);
    repeat (LEN_B + 1) q_b.push_back(1'b0);
  endtask

  task automatic drive_bit(input bit b);
    @(negedge clk);
    din = b;
    q_a.push_back(b);
    q_b.push_back(b);
  endtask

  task automatic release_reset();
    @(negedge clk);
    prefill();
    rel_edge = edges;
    first_a = 1;
    first_b = 1;
    sb_on = 1;
    din = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  always @(posedge clk) edges++;

  always @(negedge clk) begin
    if (sb_on && wclk_a && !prev_a) begin
      if (q_a.size() >= 4) begin
        for (int i = 0; i < 4; i++) exp_a[i] = q_a.pop_front();
        chk(win_a == exp_a, "R1 R2 R4 window A", win_a, exp_a);
      end
      if (first_a) begin
        chk(edges - rel_edge == 4, "R7 first strobe A", edges - rel_edge, 4);
        first_a = 0;
      end else begin
        chk(edges - last_a == 4, "R3 strobe period A", edges - last_a, 4);
      end
      last_a = edges;
      if (count_on) ones_a += $countones(win_a);
    end
    prev_a = wclk_a;
  end

  always @(negedge clk) begin
    if (sb_on && wclk_b && !prev_b) begin
      if (q_b.size() >= 4) begin
        for (int i = 0; i < 4; i++) exp_b[i] = q_b.pop_front();
        chk(win_b == exp_b, "R4 R5 window B", win_b, exp_b);
      end
      if (first_b) begin
        chk(edges - rel_edge == 4, "R7 first strobe B", edges - rel_edge, 4);
        first_b = 0;
      end else begin
        chk(edges - last_b == 4, "R3 strobe period B", edges - last_b, 4);
      end
      last_b = edges;
    end
    prev_b = wclk_b;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    repeat (5) @(negedge clk);
    chk(win_a == 4'h0 && !wclk_a, "R6 reset state A", {wclk_a, win_a}, 0);
    chk(win_b == 4'h0 && !wclk_b, "R6 reset state B", {wclk_b, win_b}, 0);

    release_reset();
    for (int n = 0; n < 320; n++) drive_bit(1'($urandom(seed + n)));
    repeat (LEN_A + 8) drive_bit(1'b0);
    count_on = 1;
    drive_bit(1'b1);
    repeat (2 * LEN_A) drive_bit(1'b0);
    count_on = 0;
    chk(ones_a == 1, "R8 single upset seen once", ones_a, 1);

    repeat (LEN_A + 8) drive_bit(1'b1);
    chk(win_a == 4'hF && win_b == 4'hF, "R1 all-ones at tail", {win_a, win_b}, 8'hFF);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    sb_on = 0;
    #0.5;
    chk(win_a == 4'h0 && !wclk_a, "R6 async clear A", {wclk_a, win_a}, 0);
    chk(win_b == 4'h0 && !wclk_b, "R6 async clear B", {wclk_b, win_b}, 0);
    repeat (4) @(negedge clk);
    chk(win_a == 4'h0 && win_b == 4'h0, "R6 held in reset", {win_a, win_b}, 0);

    release_reset();
    for (int n = 0; n < 400; n++) drive_bit(n[0]);
    repeat (20) drive_bit(1'b0);
    repeat (8) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule